// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps events on external input pins. Each of its channels watches one pin, waits for the edge that software has chosen, and then copies the value of a shared free-running timebase into that channel's capture register. Software can read two such snapshots and subtract them to get a pulse width or a period. The timebase counter is outside this block and arrives on an input bus.

Every capture sets a sticky capture flag. The flag drives the channel's interrupt request when that channel's interrupt is enabled. Every capture also produces a single-cycle DMA request pulse, which an external DMA controller can use as a transfer trigger. Each pin passes through a two-flop synchronizer before edge detection. The channels share only the timebase, and each has its own edge selection, interrupt enable and flag clear.

Top module: `edge_capture_unit`

## Requirements
- R1: While reset is held and for as long as no edge has been captured afterwards, every capture register reads 0, and every flag, interrupt and DMA request output is 0.
- R2: Edge select code 2'b01 (bits [2i+1:2i] of `edge_sel` for channel i) makes a 0-to-1 change on that channel's pin cause a capture. A 1-to-0 change causes none.
- R3: Edge select code 2'b10 makes a 1-to-0 change on the pin cause a capture. A 0-to-1 change causes none.
- R4: Edge select codes 2'b00 and 2'b11 disable the channel. Pin changes then leave the capture register, the flag and the DMA request unchanged.
- R5: A pin change that is first sampled at clock edge E0 is captured at edge E2. The register then holds the timebase value that was present between E1 and E2.
- R6: A capture sets the channel flag at the same edge as the register load. The flag stays set until a `flag_clr` pulse, and it reads 0 after the first clock edge at which `flag_clr` is high with no capture.
- R7: A capture while the flag is still set overwrites the capture register with the new timebase value, and the flag stays set.
- R8: The interrupt output of a channel equals its flag ANDed with its `irq_en` bit.
- R9: Each capture produces a DMA request pulse exactly one clock cycle long. The pulse starts at the same edge as the register load and does not depend on `irq_en`.
- R10: A capture on one channel leaves the capture register, the flag and the DMA request of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| timebase | input | CNT_W | Shared free-running count value |
| cap_in | input | NUM_CH | Asynchronous capture pins, one per channel |
| edge_sel | input | 2*NUM_CH | Per-channel edge select: 01 rising, 10 falling, 00/11 off |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| flag_clr | input | NUM_CH | Per-channel flag clear strobe |
| cap_val | output | NUM_CH*CNT_W | Capture registers, channel i at bits [CNT_W*i +: CNT_W] |
| cap_flag | output | NUM_CH | Sticky capture flags |
| irq | output | NUM_CH | Interrupt requests |
| dma_req | output | NUM_CH | One-cycle DMA trigger per capture |

## Verification
A wrong synchronizer or previous-level register shows up at the ports as a capture on the wrong edge, a doubled capture, or a missing capture. Any of these is visible within three clocks of the pin change, in the flag and in the DMA pulse count. If the register loads one cycle too early or too late, the captured value is off by one. A running timebase exposes that error on the first capture. A flag that fails to hold or to clear shows on `irq` in the cycle after the clear strobe or after the capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_OFF2 = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/cap_rst_sync.sv
module cap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl_now,
  output logic lvl_prev
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign lvl_now  = chain_q[STAGES-1];
  assign lvl_prev = prev_q;
endmodule

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
  import cap_pkg::*;
(
  input  edge_mode_e mode,
  input  logic       lvl_now,
  input  logic       lvl_prev,
  output logic       hit
);
  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = lvl_now & ~lvl_prev;
      EDGE_FALL: hit = ~lvl_now & lvl_prev;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] timebase,
  input  logic             pin,
  input  edge_mode_e       mode,
  input  logic             irq_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             irq,
  output logic             dma_req
);
  logic             lvl_now, lvl_prev, hit;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             flag_q, flag_d;
  logic             dma_q, dma_d;

  cap_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin),
    .lvl_now(lvl_now), .lvl_prev(lvl_prev)
  );

  cap_edge_detect u_det (
    .mode(mode), .lvl_now(lvl_now), .lvl_prev(lvl_prev), .hit(hit)
  );

  always_comb begin
    cap_d  = hit ? timebase : cap_q;
    flag_d = hit ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
    dma_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      flag_q <= flag_d;
      dma_q  <= dma_d;
    end
  end

  assign cap_val  = cap_q;
  assign cap_flag = flag_q;
  assign irq      = flag_q & irq_en;
  assign dma_req  = dma_q;

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode == EDGE_RISE || mode == EDGE_FALL) |=> $stable(cap_q));

  // R5
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> cap_q == $past(timebase));

  // R9
  dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> flag_q);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit) |=> !flag_q);
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int CNT_W      = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        timebase,
  input  logic [NUM_CH-1:0]       cap_in,
  input  logic [2*NUM_CH-1:0]     edge_sel,
  input  logic [NUM_CH-1:0]       irq_en,
  input  logic [NUM_CH-1:0]       flag_clr,
  output logic [NUM_CH*CNT_W-1:0] cap_val,
  output logic [NUM_CH-1:0]       cap_flag,
  output logic [NUM_CH-1:0]       irq,
  output logic [NUM_CH-1:0]       dma_req
);
  logic rst_n_int;

  cap_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    edge_mode_e mode;
    assign mode = edge_mode_e'(edge_sel[2*i +: 2]);

    cap_channel #(.CNT_W(CNT_W), .SYNC_DEPTH(SYNC_DEPTH)) u_ch (
      .clk(clk), .rst_n(rst_n_int), .timebase(timebase),
      .pin(cap_in[i]), .mode(mode), .irq_en(irq_en[i]),
      .flag_clr(flag_clr[i]),
      .cap_val(cap_val[CNT_W*i +: CNT_W]), .cap_flag(cap_flag[i]),
      .irq(irq[i]), .dma_req(dma_req[i])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |-> (cap_flag == '0 && dma_req == '0));
endmodule

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;
  localparam int NUM_CH = 2;
  localparam int CNT_W  = 16;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [CNT_W-1:0]        timebase;
  logic [NUM_CH-1:0]       cap_in;
  logic [2*NUM_CH-1:0]     edge_sel;
  logic [NUM_CH-1:0]       irq_en;
  logic [NUM_CH-1:0]       flag_clr;
  logic [NUM_CH*CNT_W-1:0] cap_val;
  logic [NUM_CH-1:0]       cap_flag;
  logic [NUM_CH-1:0]       irq;
  logic [NUM_CH-1:0]       dma_req;

  int checks = 0;
  int fails  = 0;
  int dma0_cnt = 0;
  int dma1_cnt = 0;
  logic run_tb = 1'b0;
  logic [CNT_W-1:0] tbc = '0;

  always #2 clk = ~clk;

  edge_capture_unit #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .timebase(timebase), .cap_in(cap_in),
    .edge_sel(edge_sel), .irq_en(irq_en), .flag_clr(flag_clr),
    .cap_val(cap_val), .cap_flag(cap_flag), .irq(irq), .dma_req(dma_req)
  );

  always @(posedge clk) tbc <= tbc + 1'b1;
  always @(negedge clk) begin
    if (dma_req[0]) dma0_cnt++;
    if (dma_req[1]) dma1_cnt++;
  end
  always_comb timebase = run_tb ? tbc : timebase_fix;
  logic [CNT_W-1:0] timebase_fix = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag(input int ch);
    flag_clr[ch] = 1'b1;
    cycles(1);
    flag_clr[ch] = 1'b0;
  endtask

  // {timebase[15:0], edge_sel[1:0], new pin level, capture expected}
  localparam int NVEC = 8;
  localparam logic [19:0] VEC [NVEC] = '{
    {16'h1111, 2'b01, 1'b1, 1'b1},
    {16'h2222, 2'b01, 1'b0, 1'b0},
    {16'h3333, 2'b10, 1'b1, 1'b0},
    {16'h4444, 2'b10, 1'b0, 1'b1},
    {16'h5555, 2'b00, 1'b1, 1'b0},
    {16'h6666, 2'b11, 1'b0, 1'b0},
    {16'hFFFF, 2'b01, 1'b1, 1'b1},
    {16'h0000, 2'b10, 1'b0, 1'b1}
  };

  initial begin
    automatic int t0;
    automatic int d0;
    automatic logic [CNT_W-1:0] exp_cap = '0;
    rst_n = 1'b0;
    cap_in = '0;
    edge_sel = 4'b0101;
    irq_en = '0;
    flag_clr = '0;
    cycles(3);
    // R1 reset state
    check("R1", cap_val, 32'h0);
    check("R1", {cap_flag, irq, dma_req}, 32'h0);
    rst_n = 1'b1;
    cycles(4);
    check("R1", cap_val, 32'h0);
    check("R1", {cap_flag, irq, dma_req}, 32'h0);

    // Table walk on channel 0 (R2, R3, R4, R9)
    for (int k = 0; k < NVEC; k++) begin
      timebase_fix   = VEC[k][19:4];
      edge_sel[1:0]  = VEC[k][3:2];
      clear_flag(0);
      d0 = dma0_cnt;
      cap_in[0] = VEC[k][1];
      cycles(5);
      if (VEC[k][0]) exp_cap = VEC[k][19:4];
      check(VEC[k][0] ? (VEC[k][3:2] == 2'b01 ? "R2" : "R3") : "R4",
            cap_val[15:0], exp_cap);
      check("R4 flag", cap_flag[0], VEC[k][0]);
      check("R9 dma count", dma0_cnt - d0, VEC[k][0]);
    end

    // R8 interrupt gating (flag set from last vector)
    check("R8 masked", irq[0], 1'b0);
    irq_en[0] = 1'b1;
    cycles(1);
    check("R8 enabled", irq[0], 1'b1);
    clear_flag(0);
    check("R6 cleared", cap_flag[0], 1'b0);
    check("R8 after clear", irq[0], 1'b0);

    // R7 overwrite while flag set
    edge_sel[1:0] = 2'b01;
    timebase_fix = 16'hAAAA;
    cap_in[0] = 1'b1;
    cycles(5);
    cap_in[0] = 1'b0;
    cycles(3);
    timebase_fix = 16'hBBBB;
    cap_in[0] = 1'b1;
    cycles(5);
    check("R7 overwrite", cap_val[15:0], 16'hBBBB);
    check("R6 sticky", cap_flag[0], 1'b1);

    // R10 independence: capture on channel 1 only
    edge_sel[3:2] = 2'b10;
    cap_in[1] = 1'b1;
    cycles(5);
    check("R10 no capture on rise", cap_flag[1], 1'b0);
    timebase_fix = 16'hC0DE;
    d0 = dma0_cnt;
    cap_in[1] = 1'b0;
    cycles(5);
    check("R10 ch1 value", cap_val[31:16], 16'hC0DE);
    check("R10 ch0 value", cap_val[15:0], 16'hBBBB);
    check("R10 ch0 dma", dma0_cnt - d0, 0);
    check("R10 ch1 dma", dma1_cnt, 1);

    // R5 and R9 timing with a running timebase
    clear_flag(0);
    run_tb = 1'b1;
    cap_in[0] = 1'b0;
    cycles(5);
    clear_flag(0);
    irq_en[0] = 1'b0;
    t0 = int'(tbc);
    cap_in[0] = 1'b1;
    cycles(2);
    check("R5 not early", dma_req[0], 1'b0);
    cycles(1);
    check("R9 pulse start", dma_req[0], 1'b1);
    check("R5 value", cap_val[15:0], 16'(t0 + 2));
    cycles(1);
    check("R9 pulse end", dma_req[0], 1'b0);
    check("R6 set", cap_flag[0], 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule